// File: doc/BRIEF.md
# Hot-Plug Expander SMBus Manager

This block drives an external I/O expander that carries the hot-plug control and status signals of the downstream ports (ports 1 to 11; the upstream port 0 has none). It sits in front of a byte-level SMBus master engine and tells that engine what to do, one command at a time: send a start with an address byte, write a byte, read a byte, or send a stop. The bit-level engine, bus arbitration and EEPROM loading sit outside this block.

The expander is only ever accessed as a whole. When any bit of the hot-plug output vector changes, the block writes every output bit as a two-byte snapshot, low byte first. When the expander's active-low interrupt is asserted, the block reads every input bit back as a two-byte snapshot and publishes it only if the transaction finished cleanly. A read request takes precedence over a pending write. A NACK ends the transaction with a stop, sets a sticky error flag and causes one retry. The four master-side address pins are captured once, on the first clock after reset is released. No traffic starts before the post-reset configuration phase has been reported complete.

Top module: `hpx_mgr`

## Requirements
- R1: After reset, `cmd_valid`, `err_flag` and `hp_in` are 0. No command is issued until `cfg_done` has been seen high, even if outputs changed or the interrupt was asserted earlier.
- R2: `mst_addr` takes the value of `addr_pins` on the first clock edge at which `rst_n` is high. Later changes on `addr_pins` have no effect until the next reset.
- R3: A change on `hp_out` produces one write transaction. It consists of start (code 0) with data `{EXP_ADDR,1'b0}`, write byte (code 1) with `hp_out[7:0]`, write byte with `hp_out[15:8]`, and stop (code 3). The value written is the one present when the transaction is launched.
- R4: If `hp_out` changes one or more times while a transaction is in progress, exactly one further write follows, and it carries the latest value.
- R5: While `exp_int_n` is low, the block issues a read transaction. It consists of start with `{EXP_ADDR,1'b1}`, read byte (code 2) for the low byte, read byte with `cmd_last`=1 for the high byte, and stop. `hp_in` takes the two bytes on the clock edge that accepts the stop's `cmd_done`.
- R6: When an interrupt read and an output write are both pending at the idle point, the read is launched first. The write follows.
- R7: If `exp_int_n` is still low when a read completes, another read is launched without any new edge on the interrupt.
- R8: A `cmd_done` with `cmd_ack`=0 on a start or write byte is followed at once by a stop, and `err_flag` is set and stays set until reset. The same transaction is then retried once; a second NACK abandons it.
- R9: `hp_in` changes only at the end of a read transaction in which every byte was acknowledged. An abandoned read leaves it unchanged.
- R10: `cmd_valid` is low whenever no transaction is in progress. While `cmd_valid` is high and `cmd_done` is low, `cmd_op` and `cmd_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done | input | 1 | Post-reset configuration complete |
| addr_pins | input | 4 | Master-side address strap pins |
| mst_addr | output | 4 | Strap value captured at reset release |
| hp_out | input | 16 | Hot-plug output vector to mirror into the expander |
| hp_in | output | 16 | Last good snapshot of expander inputs |
| exp_int_n | input | 1 | Expander interrupt, active low |
| cmd_valid | output | 1 | Command request to the byte engine |
| cmd_op | output | 2 | 0 start, 1 write byte, 2 read byte, 3 stop |
| cmd_data | output | 8 | Address byte or write data |
| cmd_last | output | 1 | Final read byte (engine answers with NACK) |
| cmd_done | input | 1 | One-cycle completion pulse from the engine |
| cmd_ack | input | 1 | Acknowledge seen for a start or write byte |
| cmd_rdata | input | 8 | Byte returned by a read command |
| err_flag | output | 1 | Sticky NACK indicator |

## Verification
Each command becomes visible on the cycle after the edge that accepts the previous `cmd_done`. A change on `hp_out` reaches `cmd_valid` two edges later: one edge registers the change and the next launches the transaction. `hp_in` must show the new snapshot at the falling edge right after the stop's `cmd_done` is taken, and the bench's engine model samples it exactly there. The other checks compare whole transactions (address byte, byte order, `cmd_last`, final expander contents and counts) at negative edges once the command port has been quiet for several cycles. This keeps them independent of the random engine latency.

// File: rtl/hpx_pkg.sv
// Shared definitions for the hot-plug expander manager.
// Assumes a two-byte snapshot in both directions.
package hpx_pkg;
    localparam int SNAP_BYTES = 2;
    localparam int SNAP_W     = 8 * SNAP_BYTES;

    // Byte-engine command codes (values are visible on the cmd_op port)
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } hpx_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_BYTE0, S_BYTE1, S_STOP
    } hpx_state_e;
endpackage

// File: rtl/hpx_addr_latch.sv
// Captures the strap pins on the first clock after synchronous reset is
// released and holds them until the next reset.
// Assumes the pins are stable around reset release.
module hpx_addr_latch #(
    parameter int PIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins,
    output logic [PIN_W-1:0] latched
);
    logic armed_q;

    // One-shot capture armed by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            latched <= '0;
        end else if (armed_q) begin
            latched <= pins;
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hpx_change_det.sv
// Tracks whether the hot-plug output vector differs from what was last
// taken for writing. Presents the vector padded to the snapshot width.
// Assumes 'take' is asserted on the cycle a write is launched; a change
// seen in that same cycle is already covered by the captured value.
module hpx_change_det
    import hpx_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OUT_W-1:0]  vec,
    input  logic              take,
    output logic              pending,
    output logic [SNAP_W-1:0] snap
);
    logic [OUT_W-1:0] prev_q;

    // Pad the output vector to the snapshot width
    generate
        if (OUT_W < SNAP_W) begin : g_pad
            assign snap = {{(SNAP_W-OUT_W){1'b0}}, vec};
        end else begin : g_full
            assign snap = vec[SNAP_W-1:0];
        end
    endgenerate

    // Edge detection on the vector and dirty flag upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pending <= 1'b0;
        end else begin
            prev_q  <= vec;
            pending <= take ? 1'b0 : (pending | (vec != prev_q));
        end
    end
endmodule

// File: rtl/hpx_xact_fsm.sv
// Sequences whole-snapshot read and write transactions on the byte engine.
// Reads win over writes. A NACK leads to a stop, sets the sticky error and
// allows one retry. Assumes exp interrupt is already synchronous to clk.
module hpx_xact_fsm
    import hpx_pkg::*;
#(
    parameter logic [6:0] EXP_ADDR = 7'h20,
    parameter int         IN_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              rd_req,
    input  logic              wr_pending,
    input  logic [SNAP_W-1:0] wr_value,
    output logic              wr_take,
    output logic [IN_W-1:0]   rd_snap,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_data,
    output logic              cmd_last,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    input  logic [7:0]        cmd_rdata,
    output logic              err_flag
);
    hpx_state_e        st_q;
    hpx_op_e           op_sel;
    logic              ready_q, is_rd_q, retried_q, abort_q;
    logic [SNAP_W-1:0] snap_q;
    logic              launch_rd, launch_wr;

    assign launch_rd = (st_q == S_IDLE) && ready_q && rd_req;
    assign launch_wr = (st_q == S_IDLE) && ready_q && !rd_req && wr_pending;
    assign wr_take   = launch_wr;

    // Command decode from the current state
    always_comb begin
        op_sel   = OP_STOP;
        cmd_data = 8'h00;
        unique case (st_q)
            S_ADDR: begin
                op_sel   = OP_START;
                cmd_data = {EXP_ADDR, is_rd_q};
            end
            S_BYTE0: begin
                op_sel   = is_rd_q ? OP_READ : OP_WRITE;
                cmd_data = is_rd_q ? 8'h00 : snap_q[7:0];
            end
            S_BYTE1: begin
                op_sel   = is_rd_q ? OP_READ : OP_WRITE;
                cmd_data = is_rd_q ? 8'h00 : snap_q[15:8];
            end
            default: begin
                op_sel   = OP_STOP;
                cmd_data = 8'h00;
            end
        endcase
    end

    assign cmd_valid = (st_q != S_IDLE);
    assign cmd_op    = op_sel;
    assign cmd_last  = (st_q == S_BYTE1) && is_rd_q;

    // Transaction sequencing, retry and snapshot publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            ready_q   <= 1'b0;
            is_rd_q   <= 1'b0;
            retried_q <= 1'b0;
            abort_q   <= 1'b0;
            snap_q    <= '0;
            rd_snap   <= '0;
            err_flag  <= 1'b0;
        end else begin
            if (cfg_done) ready_q <= 1'b1;
            unique case (st_q)
                S_IDLE: begin
                    if (launch_rd || launch_wr) begin
                        is_rd_q   <= launch_rd;
                        retried_q <= 1'b0;
                        abort_q   <= 1'b0;
                        st_q      <= S_ADDR;
                        if (launch_wr) snap_q <= wr_value;
                    end
                end
                S_ADDR: if (cmd_done) begin
                    abort_q <= !cmd_ack;
                    st_q    <= cmd_ack ? S_BYTE0 : S_STOP;
                end
                S_BYTE0: if (cmd_done) begin
                    if (is_rd_q) begin
                        snap_q[7:0] <= cmd_rdata;
                        st_q        <= S_BYTE1;
                    end else begin
                        abort_q <= !cmd_ack;
                        st_q    <= cmd_ack ? S_BYTE1 : S_STOP;
                    end
                end
                S_BYTE1: if (cmd_done) begin
                    if (is_rd_q) snap_q[15:8] <= cmd_rdata;
                    else         abort_q      <= !cmd_ack;
                    st_q <= S_STOP;
                end
                S_STOP: if (cmd_done) begin
                    if (abort_q) begin
                        err_flag <= 1'b1;
                        if (!retried_q) begin
                            retried_q <= 1'b1;
                            abort_q   <= 1'b0;
                            st_q      <= S_ADDR;
                        end else begin
                            st_q <= S_IDLE;
                        end
                    end else begin
                        if (is_rd_q) rd_snap <= snap_q[IN_W-1:0];
                        st_q <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpx_mgr.sv
// Top of the hot-plug expander manager: strap capture, output change
// tracking and the transaction sequencer in front of a byte-level SMBus
// master engine. Assumes exp_int_n is synchronous to clk and IN_W,OUT_W<=16.
module hpx_mgr
    import hpx_pkg::*;
#(
    parameter logic [6:0] EXP_ADDR = 7'h20,
    parameter int         PIN_W    = 4,
    parameter int         OUT_W    = 16,
    parameter int         IN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done,
    input  logic [PIN_W-1:0] addr_pins,
    output logic [PIN_W-1:0] mst_addr,
    input  logic [OUT_W-1:0] hp_out,
    output logic [IN_W-1:0]  hp_in,
    input  logic             exp_int_n,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_data,
    output logic             cmd_last,
    input  logic             cmd_done,
    input  logic             cmd_ack,
    input  logic [7:0]       cmd_rdata,
    output logic             err_flag
);
    logic              wr_pending, wr_take;
    logic [SNAP_W-1:0] wr_value;

    hpx_addr_latch #(.PIN_W(PIN_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .pins(addr_pins), .latched(mst_addr)
    );

    hpx_change_det #(.OUT_W(OUT_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .vec(hp_out), .take(wr_take),
        .pending(wr_pending), .snap(wr_value)
    );

    hpx_xact_fsm #(.EXP_ADDR(EXP_ADDR), .IN_W(IN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .rd_req(!exp_int_n),
        .wr_pending(wr_pending), .wr_value(wr_value), .wr_take(wr_take),
        .rd_snap(hp_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_done(cmd_done),
        .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .err_flag(err_flag)
    );
endmodule

// File: rtl/hpx_mgr_chk.sv
// Property checker for hpx_mgr, attached by bind below.
module hpx_mgr_chk
    import hpx_pkg::*;
#(
    parameter logic [6:0] EXP_ADDR = 7'h20,
    parameter int         PIN_W    = 4,
    parameter int         IN_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_done,
    input logic [PIN_W-1:0] mst_addr,
    input logic [IN_W-1:0]  hp_in,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [7:0]       cmd_data,
    input logic             cmd_done,
    input logic             cmd_ack,
    input logic             err_flag
);
    logic cfg_seen_q;

    // Remembers whether configuration completion has been observed
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_seen_q <= 1'b0;
        else if (cfg_done) cfg_seen_q <= 1'b1;
    end

    p_quiet_before_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_seen_q |-> !cmd_valid);

    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable(mst_addr));

    p_addr_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_START) |-> (cmd_data[7:1] == EXP_ADDR));

    p_nack_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && !cmd_ack && (cmd_op == OP_START || cmd_op == OP_WRITE))
        |=> (cmd_valid && cmd_op == OP_STOP));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_done && cmd_op == OP_STOP) |=> $stable(hp_in));

    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));
endmodule

bind hpx_mgr hpx_mgr_chk #(.EXP_ADDR(EXP_ADDR), .PIN_W(PIN_W), .IN_W(IN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .mst_addr(mst_addr),
    .hp_in(hp_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_ack(cmd_ack), .err_flag(err_flag)
);

// File: tb/tb_hpx_mgr.sv
module tb_hpx_mgr;
    import hpx_pkg::*;
    localparam logic [6:0] EXP = 7'h27;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cfg_done, exp_int_n;
    logic [3:0]  addr_pins, mst_addr;
    logic [15:0] hp_out, hp_in;
    logic        cmd_valid, cmd_last, cmd_done, cmd_ack, err_flag;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_data, cmd_rdata;

    hpx_mgr #(.EXP_ADDR(EXP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .addr_pins(addr_pins),
        .mst_addr(mst_addr), .hp_out(hp_out), .hp_in(hp_in), .exp_int_n(exp_int_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_last(cmd_last), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
        .cmd_rdata(cmd_rdata), .err_flag(err_flag)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Expander and byte-engine model state
    logic [15:0] ex_in, ex_out, wbuf, rsnap, exp_hpin;
    int  n_starts = 0, n_writes = 0, n_reads = 0, n_aborts = 0;
    int  nack_start = 0, nack_wr = 0;
    bit  rw_hist [0:8191];
    bit  cur_rw, tx_ok, chk_hpin;
    int  bidx;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] start_byte(input bit rw);
        return {EXP, rw};
    endfunction

    function automatic logic [7:0] byte_of(input logic [15:0] v, input int i);
        return (i == 0) ? v[7:0] : v[15:8];
    endfunction

    // Byte-engine model: answers each command after a random latency
    initial begin
        logic [1:0] op;
        logic [7:0] d;
        cmd_done = 1'b0; cmd_ack = 1'b0; cmd_rdata = 8'h00;
        chk_hpin = 1'b0; ex_out = 16'h0; wbuf = 16'h0; rsnap = 16'h0;
        exp_hpin = 16'h0; bidx = 0; tx_ok = 1'b0; cur_rw = 1'b0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            cmd_ack  = 1'b0;
            if (chk_hpin) begin
                check(hp_in == exp_hpin, "R5 hp_in after stop", hp_in, exp_hpin);
                chk_hpin = 1'b0;
            end
            if (rst_n && cmd_valid) begin
                op = cmd_op;
                d  = cmd_data;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                case (op)
                    OP_START: begin
                        check(d[7:1] == EXP, "R3 address byte", d, start_byte(d[0]));
                        cur_rw = d[0];
                        if (n_starts < 8192) rw_hist[n_starts] = d[0];
                        n_starts++;
                        bidx  = 0;
                        rsnap = ex_in;
                        if (nack_start > 0) begin
                            nack_start--;
                            cmd_ack = 1'b0;
                        end else cmd_ack = 1'b1;
                        tx_ok = cmd_ack;
                    end
                    OP_WRITE: begin
                        if (nack_wr > 0) begin
                            nack_wr--;
                            cmd_ack = 1'b0;
                            tx_ok   = 1'b0;
                        end else begin
                            cmd_ack = 1'b1;
                            if (bidx == 0) wbuf[7:0] = d; else wbuf[15:8] = d;
                        end
                        bidx++;
                    end
                    OP_READ: begin
                        check(cmd_last == (bidx == 1), "R5 last-byte flag", cmd_last, bidx == 1);
                        cmd_rdata = byte_of(rsnap, bidx);
                        bidx++;
                    end
                    default: begin
                        if (tx_ok && bidx == 2) begin
                            if (cur_rw) begin
                                n_reads++;
                                exp_hpin = rsnap;
                                chk_hpin = 1'b1;
                            end else begin
                                ex_out = wbuf;
                                n_writes++;
                            end
                        end else n_aborts++;
                    end
                endcase
                cmd_done = 1'b1;
            end
        end
    end

    task automatic wait_quiet();
        int q = 0;
        while (q < 12) begin
            @(negedge clk);
            if (cmd_valid) q = 0; else q++;
        end
    endtask

    task automatic wait_start();
        int s = n_starts;
        while (n_starts == s) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    // Main stimulus
    initial begin
        int w0, r0, a0, s0;
        logic [15:0] v;
        void'($urandom(32'd715));
        rst_n = 1'b0; cfg_done = 1'b0; exp_int_n = 1'b1;
        hp_out = 16'h0; addr_pins = 4'hA; ex_in = 16'h0;
        repeat (4) @(negedge clk);
        check(!cmd_valid && !err_flag && hp_in == 16'h0, "R1 reset state",
              {cmd_valid, err_flag, hp_in}, 0);

        rst_n = 1'b1;
        @(negedge clk);
        addr_pins = 4'h5;
        repeat (5) @(negedge clk);
        check(mst_addr == 4'hA, "R2 strap captured and held", mst_addr, 4'hA);

        // R1: no traffic before configuration completes
        hp_out = 16'h1234;
        repeat (40) @(negedge clk);
        check(n_starts == 0, "R1 quiet before cfg_done", n_starts, 0);
        cfg_done = 1'b1;
        wait_quiet();
        check(ex_out == 16'h1234 && n_writes == 1, "R3 first write", ex_out, 16'h1234);

        hp_out = 16'hBEEF;
        wait_quiet();
        check(ex_out == 16'hBEEF, "R3 second pattern", ex_out, 16'hBEEF);
        check(!cmd_valid, "R10 idle command port", cmd_valid, 0);

        // R4: changes during a write give exactly one more write
        w0 = n_writes;
        hp_out = 16'hA1A1;
        wait_start();
        hp_out = 16'hA2A2;
        @(negedge clk);
        hp_out = 16'hA3A3;
        wait_quiet();
        check(n_writes == w0 + 2, "R4 one extra write", n_writes, w0 + 2);
        check(ex_out == 16'hA3A3, "R4 latest value", ex_out, 16'hA3A3);

        // R6: read beats pending write
        hp_out = 16'hB1B1;
        wait_start();
        s0 = n_starts;
        hp_out = 16'hB2B2;
        ex_in = 16'hC0DE;
        exp_int_n = 1'b0;
        while (n_starts == s0) @(negedge clk);
        exp_int_n = 1'b1;
        check(rw_hist[s0] == 1'b1, "R6 read launched first", rw_hist[s0], 1);
        wait_quiet();
        check(hp_in == 16'hC0DE, "R5 snapshot read", hp_in, 16'hC0DE);
        check(ex_out == 16'hB2B2, "R6 write served after read", ex_out, 16'hB2B2);

        // R7: interrupt held low keeps reading
        r0 = n_reads;
        ex_in = 16'h1111;
        exp_int_n = 1'b0;
        while (n_reads <= r0) @(negedge clk);
        ex_in = 16'h2222;
        while (n_reads <= r0 + 2) @(negedge clk);
        exp_int_n = 1'b1;
        wait_quiet();
        check(hp_in == 16'h2222, "R7 repeated read", hp_in, 16'h2222);

        // R8: NACK, retry, give up
        a0 = n_aborts;
        nack_start = 1;
        hp_out = 16'hD00D;
        wait_quiet();
        check(err_flag == 1'b1, "R8 error set", err_flag, 1);
        check(ex_out == 16'hD00D && n_aborts == a0 + 1, "R8 retry succeeds", ex_out, 16'hD00D);
        nack_start = 2;
        hp_out = 16'hE00E;
        wait_quiet();
        check(ex_out == 16'hD00D && n_aborts == a0 + 3, "R8 gives up after two", ex_out, 16'hD00D);
        nack_wr = 1;
        hp_out = 16'hF00F;
        wait_quiet();
        check(ex_out == 16'hF00F && n_aborts == a0 + 4, "R8 data NACK retry", ex_out, 16'hF00F);
        check(err_flag == 1'b1, "R8 error sticky", err_flag, 1);

        // R9: abandoned read leaves snapshot
        r0 = n_reads;
        nack_start = 2;
        ex_in = 16'h9999;
        exp_int_n = 1'b0;
        wait_start();
        exp_int_n = 1'b1;
        wait_quiet();
        check(hp_in == 16'h2222 && n_reads == r0, "R9 snapshot unchanged", hp_in, 16'h2222);

        // Constrained random phase
        for (int i = 0; i < 400; i++) begin
            int act;
            act = $urandom_range(0, 7);
            if (act < 3) hp_out = 16'($urandom);
            else if (act == 3) ex_in = 16'($urandom);
            else if (act == 4) begin
                exp_int_n = 1'b0;
                repeat ($urandom_range(1, 20)) @(negedge clk);
                exp_int_n = 1'b1;
            end else if (act == 5 && $urandom_range(0, 7) == 0) nack_start = 1;
            repeat ($urandom_range(0, 15)) @(negedge clk);
        end
        exp_int_n = 1'b1;
        wait_quiet();
        nack_start = 0;
        nack_wr = 0;
        v = 16'($urandom);
        if (v == hp_out) v = v ^ 16'h0001;
        hp_out = v;
        wait_quiet();
        check(ex_out == v, "R3 random final write", ex_out, v);
        ex_in = 16'($urandom);
        exp_int_n = 1'b0;
        wait_start();
        exp_int_n = 1'b1;
        wait_quiet();
        check(hp_in == ex_in, "R5 random final read", hp_in, ex_in);
        check(!cmd_valid, "R10 idle after random", cmd_valid, 0);

        finish_run();
    end
endmodule